// File: doc/BRIEF.md
# Cascadable Configuration Stream Reader

This block models the read side of a configuration memory that feeds a stored bitstream to a consuming device. A small on-chip byte array holds the image. A synchronous write port fills it for test. On every rising clock edge while the device is selected, the block registers the next element onto its data pins. An element is one whole byte in byte-wide mode, or a single bit on pin 0 in bit-serial mode. In bit-serial mode each stored byte goes out most-significant bit first. The pins are tri-stated whenever the device is not presenting data, so several devices can share one data bus.

Devices chain through a hand-off output. When a device has exhausted its stored length, its hand-off output rises and it releases the bus. That output feeds the chip enable of the next device, which then takes over the stream. The output-enable input also acts as an active-low reset of the read position. A per-pin drive-enable vector is brought out next to the data pins so that the tri-state condition can be seen.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `oe_rst_i` is low, the next rising edge returns the read position to byte 0 bit 7 and clears the exhausted flag. While `oe_rst_i` is low, `cascade_o` and `data_oe_o` are 0.
- R2: A pin is driven (its `data_oe_o` bit is 1) only when `enable_i` and `oe_rst_i` are both high and the previous enabled edge presented an element. Otherwise `data_o` is high impedance and `data_oe_o` is 0.
- R3: When `par_mode_i` is 1 (byte-wide mode), each enabled edge registers stored byte k onto `data_o[7:0]`, with k = 0, 1, … LEN-1 in order, and `data_oe_o` = 8'hFF.
- R4: When `par_mode_i` is 0 (bit-serial mode), each enabled edge registers one bit onto `data_o[0]`, bit 7 first, and moves to the next byte after eight edges. `data_oe_o` = 8'h01, so pins 7..1 stay undriven.
- R5: On the enabled edge after the last element has been presented, the block stops driving and `cascade_o` rises.
- R6: `cascade_o` stays high while `enable_i` and `oe_rst_i` stay high. It drops in the same cycle that `enable_i` falls, and no further data is presented.
- R7: With `oe_rst_i` high and `enable_i` low, the read position holds and the pins are released. When the device is enabled again, the stream resumes at the element that comes next.
- R8: A rising edge with `wr_en_i` high stores `wr_data_i` at byte `wr_addr_i`. Later streams present the new value.
- R9: In a chain where each device's `cascade_o` drives the next device's `enable_i`, the bus carries the concatenation of the stored images. No two devices ever drive the bus in the same cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, may run freely |
| enable_i | input | 1 | Chip enable, active high |
| oe_rst_i | input | 1 | Output enable when high, read-position reset when low |
| par_mode_i | input | 1 | 1 = byte-wide output, 0 = bit-serial on pin 0 |
| wr_en_i | input | 1 | Test write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Test write byte address |
| wr_data_i | input | 8 | Test write byte |
| data_o | output | 8 | Tri-stated data pins |
| data_oe_o | output | 8 | Per-pin drive enable of `data_o` |
| cascade_o | output | 1 | Hand-off enable for the next device |

## Verification
Two chained devices are loaded with distinct images of different lengths. The byte-wide stream then tells correct byte order and the hand-off point apart from an off-by-one in the length compare. The same images streamed bit-serially separate MSB-first from LSB-first order and check the eight-edge byte stride. They also show that pins 7..1 stay released in that mode. Directed sequences cover a pause in mid-stream, a chip enable that falls after hand-off, a reset partway through a stream, and a rewrite through the test port. Together these tell holding the position apart from restarting the stream, and a hand-off that drops with the enable apart from one that stays set.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } out_mode_e;
endpackage

// File: rtl/cfgr_store.sv
module cfgr_store
    import cfgr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WAW   = $clog2(DEPTH),
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           wr_en_i,
    input  logic [WAW-1:0] wr_addr_i,
    input  byte_t          wr_data_i,
    input  logic [AW-1:0]  rd_addr_i,
    output byte_t          rd_data_o
);
    byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        if (rd_addr_i < AW'(DEPTH)) begin
            rd_data_o = mem_q[rd_addr_i[WAW-1:0]];
        end else begin
            rd_data_o = '0;
        end
    end
endmodule

// File: rtl/cfgr_seq.sv
module cfgr_seq
    import cfgr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN   = 16,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          oe_rst_i,
    input  logic          enable_i,
    input  logic          par_i,
    input  byte_t         rd_byte_i,
    output logic [AW-1:0] rd_addr_o,
    output byte_t         out_o,
    output logic          drive_o,
    output logic          par_o,
    output logic          done_o
);
    localparam logic [AW-1:0] END_ADDR = AW'(LEN);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [2:0]    bit_idx;
        byte_t         out;
        logic          drive;
        logic          par;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;
    logic run;

    assign run = oe_rst_i && enable_i && !st_q.done;

    always_comb begin
        st_d       = st_q;
        st_d.drive = 1'b0;
        if (!oe_rst_i) begin
            st_d = '0;
        end else if (run) begin
            if (st_q.addr == END_ADDR) begin
                st_d.done = 1'b1;
            end else begin
                st_d.drive = 1'b1;
                st_d.par   = par_i;
                if (out_mode_e'(par_i) == MODE_PARALLEL) begin
                    st_d.out     = rd_byte_i;
                    st_d.addr    = st_q.addr + 1'b1;
                    st_d.bit_idx = '0;
                end else begin
                    st_d.out     = {7'b0, rd_byte_i[~st_q.bit_idx]};
                    st_d.bit_idx = st_q.bit_idx + 1'b1;
                    if (st_q.bit_idx == 3'd7) begin
                        st_d.addr = st_q.addr + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_addr_o = st_q.addr;
    assign out_o     = st_q.out;
    assign drive_o   = st_q.drive;
    assign par_o     = st_q.par;
    assign done_o    = st_q.done;

    // R1: holding reset clears the position and the exhausted flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !oe_rst_i |=> (st_q.addr == '0 && st_q.bit_idx == '0 && !st_q.done && !st_q.drive));

    // R3: a byte-wide step advances one byte
    a_r3_byte_step: assert property (@(posedge clk) disable iff (!oe_rst_i)
        (run && par_i && st_q.addr != END_ADDR) |=> (st_q.addr == $past(st_q.addr) + 1'b1));

    // R4: a bit-serial step moves to the next byte only after bit 0
    a_r4_serial_stride: assert property (@(posedge clk) disable iff (!oe_rst_i)
        (run && !par_i && st_q.addr != END_ADDR && st_q.bit_idx != 3'd7)
            |=> (st_q.addr == $past(st_q.addr)));

    // R5: reaching the end raises the exhausted flag and stops driving
    a_r5_end_handoff: assert property (@(posedge clk) disable iff (!oe_rst_i)
        (run && st_q.addr == END_ADDR) |=> (st_q.done && !st_q.drive));

    // R5: nothing is presented once exhausted
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (!oe_rst_i)
        st_q.done |-> !st_q.drive);

    // R7: a deselected device keeps its place
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!oe_rst_i)
        (oe_rst_i && !enable_i) |=> ($stable(st_q.addr) && $stable(st_q.bit_idx) && !st_q.drive));
endmodule

// File: rtl/cfgr_pads.sv
module cfgr_pads
    import cfgr_pkg::*;
(
    input  logic       drive_i,
    input  logic       par_i,
    input  logic       enable_i,
    input  logic       oe_rst_i,
    input  byte_t      out_i,
    output logic [7:0] pin_o,
    output logic [7:0] pin_oe_o
);
    logic live;

    assign live = drive_i && enable_i && oe_rst_i;

    for (genvar i = 0; i < 8; i++) begin : g_pin
        if (i == 0) begin : g_lsb
            assign pin_oe_o[i] = live;
        end else begin : g_upper
            assign pin_oe_o[i] = live && par_i;
        end
        assign pin_o[i] = pin_oe_o[i] ? out_i[i] : 1'bz;
    end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfgr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN   = 16,
    localparam int WAW  = $clog2(DEPTH),
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           enable_i,
    input  logic           oe_rst_i,
    input  logic           par_mode_i,
    input  logic           wr_en_i,
    input  logic [WAW-1:0] wr_addr_i,
    input  logic [7:0]     wr_data_i,
    output logic [7:0]     data_o,
    output logic [7:0]     data_oe_o,
    output logic           cascade_o
);
    logic [AW-1:0] rd_addr;
    byte_t         rd_byte;
    byte_t         out_byte;
    logic          drive;
    logic          par_q;
    logic          done;

    cfgr_store #(.DEPTH(DEPTH), .WAW(WAW), .AW(AW)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_byte)
    );

    cfgr_seq #(.DEPTH(DEPTH), .LEN(LEN), .AW(AW)) u_seq (
        .clk       (clk),
        .oe_rst_i  (oe_rst_i),
        .enable_i  (enable_i),
        .par_i     (par_mode_i),
        .rd_byte_i (rd_byte),
        .rd_addr_o (rd_addr),
        .out_o     (out_byte),
        .drive_o   (drive),
        .par_o     (par_q),
        .done_o    (done)
    );

    cfgr_pads u_pads (
        .drive_i  (drive),
        .par_i    (par_q),
        .enable_i (enable_i),
        .oe_rst_i (oe_rst_i),
        .out_i    (out_byte),
        .pin_o    (data_o),
        .pin_oe_o (data_oe_o)
    );

    assign cascade_o = done && enable_i && oe_rst_i;

    // R2: a deselected or reset device never drives the bus
    a_r2_release: assert property (@(posedge clk) disable iff (!oe_rst_i)
        !enable_i |-> (data_oe_o == '0));

    // R5: hand-off and driving are mutually exclusive
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!oe_rst_i)
        cascade_o |-> (data_oe_o == '0));

    // R4: pin enables are either none, pin 0 alone, or all pins
    a_r4_pin_shape: assert property (@(posedge clk) disable iff (!oe_rst_i)
        (data_oe_o == 8'h00) || (data_oe_o == 8'h01) || (data_oe_o == 8'hFF));
endmodule

// File: tb/test_cfg_stream_reader.sv
`timescale 1ns/100ps
module test_cfg_stream_reader;
    localparam int DEPTH = 8;
    localparam int LEN_A = 3;
    localparam int LEN_B = 2;
    localparam int WAW   = $clog2(DEPTH);

    localparam logic [7:0] PAT_A [LEN_A] = '{8'hA5, 8'h3C, 8'hF0};
    localparam logic [7:0] PAT_B [LEN_B] = '{8'h81, 8'h5E};

    // byte-wide chain vectors: {bus driven, byte, cascade A, cascade B}
    localparam int NPAR = 8;
    localparam logic [10:0] PAR_TAB [NPAR] = '{
        {1'b1, 8'hA5, 1'b0, 1'b0},
        {1'b1, 8'h3C, 1'b0, 1'b0},
        {1'b1, 8'hF0, 1'b0, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 8'h81, 1'b1, 1'b0},
        {1'b1, 8'h5E, 1'b1, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           ce, oe, par;
    logic           we_a, we_b;
    logic [WAW-1:0] wa;
    logic [7:0]     wd;
    wire  [7:0]     d_a, d_b;
    logic [7:0]     oe_a, oe_b;
    logic           cas_a, cas_b;
    logic [7:0]     bus;
    int             total = 0;
    int             bad = 0;
    bit             finished = 1'b0;

    cfg_stream_reader #(.DEPTH(DEPTH), .LEN(LEN_A)) i_cfg_stream_reader (
        .clk(clk), .enable_i(ce), .oe_rst_i(oe), .par_mode_i(par),
        .wr_en_i(we_a), .wr_addr_i(wa), .wr_data_i(wd),
        .data_o(d_a), .data_oe_o(oe_a), .cascade_o(cas_a)
    );

    cfg_stream_reader #(.DEPTH(DEPTH), .LEN(LEN_B)) i_cfg_stream_reader_b (
        .clk(clk), .enable_i(cas_a), .oe_rst_i(oe), .par_mode_i(par),
        .wr_en_i(we_b), .wr_addr_i(wa), .wr_data_i(wd),
        .data_o(d_b), .data_oe_o(oe_b), .cascade_o(cas_b)
    );

    assign bus = (oe_a != 8'h00) ? (d_a & oe_a) : (d_b & oe_b);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        check("R9 single driver", 32'(|(oe_a & oe_b)), 32'd0);
    endtask

    task automatic restart();
        oe = 1'b0;
        tick();
        oe = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ce = 1'b0; oe = 1'b0; par = 1'b1;
        we_a = 1'b0; we_b = 1'b0; wa = '0; wd = '0;

        // load images through the test port (R8)
        for (int i = 0; i < LEN_A; i++) begin
            we_a = 1'b1; wa = WAW'(i); wd = PAT_A[i];
            tick();
        end
        we_a = 1'b0;
        for (int i = 0; i < LEN_B; i++) begin
            we_b = 1'b1; wa = WAW'(i); wd = PAT_B[i];
            tick();
        end
        we_b = 1'b0;

        // R1 reset state
        ce = 1'b1;
        tick();
        check("R1 oe A in reset", 32'(oe_a), 32'h0);
        check("R1 cascade A in reset", 32'(cas_a), 32'd0);
        check("R1 cascade B in reset", 32'(cas_b), 32'd0);

        // R3 R5 R9 byte-wide chain from the vector table
        oe = 1'b1;
        for (int k = 0; k < NPAR; k++) begin
            tick();
            check("R3 R9 bus driven", 32'(oe_a != 0 || oe_b != 0), 32'(PAR_TAB[k][10]));
            if (PAR_TAB[k][10]) begin
                check("R3 pin enables", 32'(oe_a | oe_b), 32'hFF);
                check("R3 R9 byte", 32'(bus), 32'(PAR_TAB[k][9:2]));
            end
            check("R5 cascade A", 32'(cas_a), 32'(PAR_TAB[k][1]));
            check("R5 cascade B", 32'(cas_b), 32'(PAR_TAB[k][0]));
        end

        // R4 R9 bit-serial chain
        par = 1'b0;
        restart();
        for (int i = 0; i < LEN_A * 8; i++) begin
            tick();
            check("R4 serial A enables", 32'(oe_a), 32'h01);
            check("R4 serial A bit", 32'(bus[0]), 32'(PAT_A[i / 8][7 - (i % 8)]));
        end
        tick();
        check("R5 serial gap", 32'(oe_a | oe_b), 32'h0);
        check("R5 serial cascade A", 32'(cas_a), 32'd1);
        for (int i = 0; i < LEN_B * 8; i++) begin
            tick();
            check("R4 serial B enables", 32'(oe_b), 32'h01);
            check("R4 R9 serial B bit", 32'(bus[0]), 32'(PAT_B[i / 8][7 - (i % 8)]));
        end
        tick();
        check("R5 serial cascade B", 32'(cas_b), 32'd1);
        check("R5 serial end quiet", 32'(oe_a | oe_b), 32'h0);

        // R7 pause mid-stream
        par = 1'b1;
        restart();
        tick();
        check("R7 first byte", 32'(bus), 32'hA5);
        ce = 1'b0;
        #1;
        check("R2 released on deselect", 32'(oe_a), 32'h0);
        tick();
        tick();
        check("R7 paused quiet", 32'(oe_a | oe_b), 32'h0);
        check("R7 paused no cascade", 32'(cas_a), 32'd0);
        ce = 1'b1;
        tick();
        check("R7 resumes next byte", 32'(bus), 32'h3C);
        tick();
        tick();
        check("R5 handoff after resume", 32'(cas_a), 32'd1);

        // R6 cascade follows the enable
        ce = 1'b0;
        #1;
        check("R6 cascade drops", 32'(cas_a), 32'd0);
        check("R6 downstream quiet", 32'(oe_b), 32'h0);
        tick();
        check("R6 no data after drop", 32'(oe_a | oe_b), 32'h0);
        ce = 1'b1;
        #1;
        check("R6 cascade returns", 32'(cas_a), 32'd1);
        tick();
        check("R6 downstream starts", 32'(bus), 32'h81);

        // R1 reset mid-stream
        oe = 1'b0;
        #1;
        check("R1 release in reset", 32'(oe_a | oe_b), 32'h0);
        tick();
        check("R1 cascade cleared", 32'(cas_a), 32'd0);
        oe = 1'b1;
        tick();
        check("R1 restart at byte 0", 32'(bus), 32'hA5);

        // R8 rewrite byte 0 of device A
        we_a = 1'b1; wa = '0; wd = 8'h77;
        tick();
        we_a = 1'b0;
        restart();
        tick();
        check("R8 rewritten byte", 32'(bus), 32'h77);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule